// File: doc/BRIEF.md
# Single-Wire Parity Chunk Framer

This block moves one chunk of 1 to `MAX_BITS` bits across a single open-drain line that has a pull-up. It has a transmit side and a receive side. Each side is started for one chunk at a time, and the chunk length is given again with every start. The line is modelled as three signals: an output enable, an output value and the sampled line level. A bit that the block releases reads back as high.

A transmitted chunk starts with a sync pulse. The sender pulls the line low for one bit period and then drives it high for one clock cycle. The data bits follow, most significant first, and then an even-parity bit. After that the sender keeps the line driven low, so the next sync pulse produces a fresh rising edge. The receiver is armed before the sender starts. It locks onto the rising edge of the sync pulse, samples every bit partway into the bit, and reports the word together with a parity-error flag. If no sync edge arrives within a fixed window, it gives up and returns to idle.

All timing is counted in system-clock cycles from the parameter `BIT_CYC`. Two copies of the block can share one wired-AND line, one copy sending and one receiving.

Top module: `swire_parity_framer`

## Requirements
- R1: After reset the line is released (`lineOe`=0). `txBusy`, `txDone`, `rxBusy`, `rxDone` and `rxTimeout` are all low.
- R2: Accepting `txStart` starts a chunk. The line is driven low for exactly `BIT_CYC` cycles and then driven high for exactly one cycle.
- R3: The low `txLen` bits of `txData` follow the sync pulse, most significant first, each held for `BIT_CYC` cycles. Both `txData` and `txLen` are captured when `txStart` is accepted.
- R4: One parity bit follows the data bits and lasts `BIT_CYC` cycles. Its value makes the number of ones across the data bits and the parity bit even.
- R5: After the parity bit the sender drives the line low (`lineOe`=1, `lineOut`=0) until its next `txStart`. `txBusy` stays high for exactly (`txLen`+2)·`BIT_CYC`+1 cycles, and `txDone` is high for exactly one cycle per chunk.
- R6: The receiver takes the line's rising edge while it waits for a high level as the start of the data. It samples each bit, parity included, floor(`BIT_CYC`/2)+1 cycles after that bit begins on the line. `rxDone` is high for one cycle, starting right after the parity sample.
- R7: `rxData` holds the received bits right-aligned. The first bit received is at position `rxLen`-1, and all higher bits are zero.
- R8: `rxParityErr` is 1 exactly when the received data bits and the received parity bit together hold an odd number of ones. It is updated together with `rxDone`.
- R9: If no rising edge has been accepted within 5·`BIT_CYC` cycles after `rxArm`, the receiver returns to idle and raises `rxTimeout` for one cycle, exactly 5·`BIT_CYC` cycles after arming. This holds whether the line sits high or is held low.
- R10: `txStart` while the transmit side is busy, and `rxArm` while the receive side is busy, have no effect on the chunk in progress.
- R11: The chunk length can be chosen per transfer, from 1 to `MAX_BITS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| txStart | input | 1 | Starts a transmit chunk when the transmit side is not busy |
| txData | input | MAX_BITS | Word to send, right-aligned |
| txLen | input | clog2(MAX_BITS+1) | Number of data bits to send (1..MAX_BITS) |
| txBusy | output | 1 | Transmit chunk in progress |
| txDone | output | 1 | One-cycle pulse when the parity bit has ended |
| rxArm | input | 1 | Arms the receiver for one chunk |
| rxLen | input | clog2(MAX_BITS+1) | Number of data bits to receive |
| rxBusy | output | 1 | Receiver armed or receiving |
| rxDone | output | 1 | One-cycle pulse when a chunk has been received |
| rxData | output | MAX_BITS | Received word, right-aligned |
| rxParityErr | output | 1 | Parity mismatch on the last received chunk |
| rxTimeout | output | 1 | One-cycle pulse when no sync edge arrived in time |
| lineOe | output | 1 | Drive enable for the shared line |
| lineOut | output | 1 | Value driven when enabled |
| lineIn | input | 1 | Sampled level of the shared line |

## Verification
The bench builds two copies with `BIT_CYC`=5 and `MAX_BITS`=8 on a wired-AND line, one sending and one receiving. A bit period this short makes it possible to sweep every data value at every length from 1 to 8. The odd period also checks that the sample offset rounds down. A pull-down the bench controls forces single bit windows low, including the parity bit, and the bench predicts the corrupted word and the error flag by arithmetic. Cycle counts of the busy window, the timing of done and the timeout window are compared against the formulas in the requirements.

// File: rtl/swf_pkg.sv
package swf_pkg;

  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic rxClear;
    logic rxSample;
    logic rxFinish;
  } swf_strobe_t;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_SYNC_LO,
    TX_SYNC_HI,
    TX_DATA,
    TX_PARITY,
    TX_HOLD
  } tx_state_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_WAIT_LO,
    RX_WAIT_HI,
    RX_BITS
  } rx_state_t;

endpackage

// File: rtl/swf_dp.sv
module swf_dp
  import swf_pkg::*;
#(
  parameter int MAX_BITS = 8,
  parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  swf_strobe_t         strobe,
  input  logic [MAX_BITS-1:0] txData,
  input  logic [LEN_W-1:0]    txLen,
  input  logic                lineIn,
  output logic                txBit,
  output logic                txPar,
  output logic [MAX_BITS-1:0] rxData,
  output logic                rxParityErr
);
  localparam int IDX_W = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;

  logic [MAX_BITS-1:0] txShiftQ;
  logic [MAX_BITS-1:0] alignedD;
  logic                loadPar;
  logic [MAX_BITS-1:0] rxShiftQ;
  logic                rxAccQ;

  // left-align the low txLen bits so the first bit to send sits at the top
  always_comb begin
    alignedD = '0;
    loadPar  = 1'b0;
    for (int k = 0; k < MAX_BITS; k++) begin
      if (k < int'(txLen)) begin
        alignedD[MAX_BITS-1-k] = txData[IDX_W'(int'(txLen) - 1 - k)];
        loadPar                = loadPar ^ txData[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShiftQ <= '0;
      txPar    <= 1'b0;
    end else if (strobe.txLoad) begin
      txShiftQ <= alignedD;
      txPar    <= loadPar;
    end else if (strobe.txShift) begin
      txShiftQ <= {txShiftQ[MAX_BITS-2:0], 1'b0};
    end
  end

  assign txBit = txShiftQ[MAX_BITS-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShiftQ    <= '0;
      rxAccQ      <= 1'b0;
      rxData      <= '0;
      rxParityErr <= 1'b0;
    end else begin
      if (strobe.rxClear) begin
        rxShiftQ <= '0;
        rxAccQ   <= 1'b0;
      end else if (strobe.rxSample) begin
        rxShiftQ <= {rxShiftQ[MAX_BITS-2:0], lineIn};
        rxAccQ   <= rxAccQ ^ lineIn;
      end
      if (strobe.rxFinish) begin
        rxData      <= rxShiftQ;
        rxParityErr <= rxAccQ ^ lineIn;
      end
    end
  end

  // R6: at most one receive action per cycle
  a_r6_rx_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.rxClear, strobe.rxSample, strobe.rxFinish}));

  // R3: a shift never coincides with a fresh load
  a_r3_load_not_shift: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.txLoad && strobe.txShift));

endmodule

// File: rtl/swf_ctrl.sv
module swf_ctrl
  import swf_pkg::*;
#(
  parameter int BIT_CYC      = 96,
  parameter int MAX_BITS     = 8,
  parameter int WAIT_PERIODS = 5,
  parameter int LEN_W        = $clog2(MAX_BITS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txStart,
  input  logic [LEN_W-1:0] txLen,
  input  logic             rxArm,
  input  logic [LEN_W-1:0] rxLen,
  input  logic             lineIn,
  input  logic             txBit,
  input  logic             txPar,
  output swf_strobe_t      strobe,
  output logic             lineOe,
  output logic             lineOut,
  output logic             txBusy,
  output logic             txDone,
  output logic             rxBusy,
  output logic             rxDone,
  output logic             rxTimeout
);
  localparam int CNT_W      = $clog2(BIT_CYC);
  localparam int HALF       = BIT_CYC / 2;
  localparam int WAIT_LIMIT = WAIT_PERIODS * BIT_CYC;
  localparam int WAIT_W     = $clog2(WAIT_LIMIT);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(BIT_CYC - 1);
  localparam logic [CNT_W-1:0]  CNT_HALF  = CNT_W'(HALF);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_LIMIT - 1);

  tx_state_t        txState;
  logic [CNT_W-1:0] txCnt;
  logic [LEN_W-1:0] txIdx;
  logic [LEN_W-1:0] txLenQ;
  logic             txIdle;

  rx_state_t         rxState;
  logic [CNT_W-1:0]  rxCnt;
  logic [LEN_W-1:0]  rxIdx;
  logic [LEN_W-1:0]  rxLenQ;
  logic [WAIT_W-1:0] waitCnt;
  logic              rxAtMid;

  assign txIdle  = (txState == TX_IDLE) || (txState == TX_HOLD);
  assign rxAtMid = (rxState == RX_BITS) && (rxCnt == CNT_HALF);

  // ---------------- transmit sequencing ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txCnt   <= '0;
      txIdx   <= '0;
      txLenQ  <= '0;
      txDone  <= 1'b0;
    end else begin
      txDone <= 1'b0;
      case (txState)
        TX_IDLE, TX_HOLD: begin
          if (txStart) begin
            txState <= TX_SYNC_LO;
            txCnt   <= '0;
            txLenQ  <= txLen;
          end
        end
        TX_SYNC_LO: begin
          if (txCnt == CNT_LAST) begin
            txState <= TX_SYNC_HI;
            txCnt   <= '0;
          end else begin
            txCnt <= txCnt + 1'b1;
          end
        end
        TX_SYNC_HI: begin
          txState <= TX_DATA;
          txCnt   <= '0;
          txIdx   <= '0;
        end
        TX_DATA: begin
          if (txCnt == CNT_LAST) begin
            txCnt <= '0;
            if (txIdx == txLenQ - 1'b1) txState <= TX_PARITY;
            else                        txIdx   <= txIdx + 1'b1;
          end else begin
            txCnt <= txCnt + 1'b1;
          end
        end
        TX_PARITY: begin
          if (txCnt == CNT_LAST) begin
            txState <= TX_HOLD;
            txCnt   <= '0;
            txDone  <= 1'b1;
          end else begin
            txCnt <= txCnt + 1'b1;
          end
        end
        default: txState <= TX_IDLE;
      endcase
    end
  end

  always_comb begin
    case (txState)
      TX_SYNC_HI: lineOut = 1'b1;
      TX_DATA:    lineOut = txBit;
      TX_PARITY:  lineOut = txPar;
      default:    lineOut = 1'b0;
    endcase
  end

  assign lineOe = (txState != TX_IDLE);
  assign txBusy = !txIdle;

  // ---------------- receive sequencing ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState   <= RX_IDLE;
      rxCnt     <= '0;
      rxIdx     <= '0;
      rxLenQ    <= '0;
      waitCnt   <= '0;
      rxDone    <= 1'b0;
      rxTimeout <= 1'b0;
    end else begin
      rxDone    <= 1'b0;
      rxTimeout <= 1'b0;
      case (rxState)
        RX_IDLE: begin
          if (rxArm) begin
            rxState <= RX_WAIT_LO;
            waitCnt <= '0;
            rxLenQ  <= rxLen;
          end
        end
        RX_WAIT_LO, RX_WAIT_HI: begin
          if (rxState == RX_WAIT_HI && lineIn) begin
            rxState <= RX_BITS;
            rxCnt   <= '0;
            rxIdx   <= '0;
          end else if (waitCnt == WAIT_LAST) begin
            rxState   <= RX_IDLE;
            rxTimeout <= 1'b1;
          end else begin
            waitCnt <= waitCnt + 1'b1;
            if (!lineIn) rxState <= RX_WAIT_HI;
          end
        end
        RX_BITS: begin
          if (rxAtMid && rxIdx == rxLenQ) begin
            rxState <= RX_IDLE;
            rxDone  <= 1'b1;
          end else if (rxCnt == CNT_LAST) begin
            rxCnt <= '0;
            rxIdx <= rxIdx + 1'b1;
          end else begin
            rxCnt <= rxCnt + 1'b1;
          end
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  assign rxBusy = (rxState != RX_IDLE);

  always_comb begin
    strobe          = '0;
    strobe.txLoad   = txStart && txIdle;
    strobe.txShift  = (txState == TX_DATA) && (txCnt == CNT_LAST);
    strobe.rxClear  = rxArm && (rxState == RX_IDLE);
    strobe.rxSample = rxAtMid && (rxIdx != rxLenQ);
    strobe.rxFinish = rxAtMid && (rxIdx == rxLenQ);
  end

  // R2: the one-cycle high mark only ever follows the low half of the sync
  a_r2_sync_order: assert property (@(posedge clk) disable iff (!rstN)
    (txState == TX_SYNC_HI) |-> ($past(txState) == TX_SYNC_LO));

  // R10: the captured length cannot move while a chunk is on the line
  a_r10_len_stable: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && $past(txBusy)) |-> $stable(txLenQ));

  // R9: the receiver never waits beyond its window
  a_r9_wait_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_WAIT_LO || rxState == RX_WAIT_HI) |-> (waitCnt <= WAIT_LAST));

endmodule

// File: rtl/swire_parity_framer.sv
module swire_parity_framer
  import swf_pkg::*;
#(
  parameter int BIT_CYC      = 96,
  parameter int MAX_BITS     = 8,
  parameter int WAIT_PERIODS = 5
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          txStart,
  input  logic [MAX_BITS-1:0]           txData,
  input  logic [$clog2(MAX_BITS+1)-1:0] txLen,
  output logic                          txBusy,
  output logic                          txDone,
  input  logic                          rxArm,
  input  logic [$clog2(MAX_BITS+1)-1:0] rxLen,
  output logic                          rxBusy,
  output logic                          rxDone,
  output logic [MAX_BITS-1:0]           rxData,
  output logic                          rxParityErr,
  output logic                          rxTimeout,
  output logic                          lineOe,
  output logic                          lineOut,
  input  logic                          lineIn
);
  localparam int LEN_W = $clog2(MAX_BITS + 1);

  swf_strobe_t strobe;
  logic        txBit;
  logic        txPar;

  swf_ctrl #(
    .BIT_CYC(BIT_CYC), .MAX_BITS(MAX_BITS),
    .WAIT_PERIODS(WAIT_PERIODS), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .txStart(txStart), .txLen(txLen),
    .rxArm(rxArm), .rxLen(rxLen),
    .lineIn(lineIn), .txBit(txBit), .txPar(txPar),
    .strobe(strobe),
    .lineOe(lineOe), .lineOut(lineOut),
    .txBusy(txBusy), .txDone(txDone),
    .rxBusy(rxBusy), .rxDone(rxDone), .rxTimeout(rxTimeout)
  );

  swf_dp #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe),
    .txData(txData), .txLen(txLen),
    .lineIn(lineIn),
    .txBit(txBit), .txPar(txPar),
    .rxData(rxData), .rxParityErr(rxParityErr)
  );

  // R5: done is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !txDone);

  // R5: when done fires the line is already held low
  a_r5_hold_low: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> (lineOe && !lineOut && !txBusy));

  // R9: a chunk cannot both complete and time out
  a_r9_done_or_timeout: assert property (@(posedge clk) disable iff (!rstN)
    !(rxDone && rxTimeout));

  // R6: received-chunk pulse is one cycle wide
  a_r6_rx_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone);

endmodule

// File: tb/swire_parity_framer_bench.sv
module swire_parity_framer_bench;
  localparam int BC   = 5;
  localparam int MB   = 8;
  localparam int LW   = $clog2(MB + 1);
  localparam int HALF = BC / 2;
  localparam int WIN  = 5 * BC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  // sender copy
  logic          aStart = 1'b0;
  logic [MB-1:0] aData = '0;
  logic [LW-1:0] aLen = '0;
  logic          aBusy, aDone, aRxBusy, aRxDone, aRxErr, aRxTo, aOe, aOut;
  logic [MB-1:0] aRxData;
  // receiver copy
  logic          bArm = 1'b0;
  logic [LW-1:0] bLen = '0;
  logic          bTxBusy, bTxDone, bBusy, bDone, bErr, bTo, bOe, bOut;
  logic [MB-1:0] bData;

  logic noise = 1'b0;
  logic line;
  assign line = !((aOe && !aOut) || (bOe && !bOut) || noise);

  swire_parity_framer #(.BIT_CYC(BC), .MAX_BITS(MB)) u_swire_parity_framer (
    .clk(clk), .rstN(rstN),
    .txStart(aStart), .txData(aData), .txLen(aLen),
    .txBusy(aBusy), .txDone(aDone),
    .rxArm(1'b0), .rxLen(LW'(0)),
    .rxBusy(aRxBusy), .rxDone(aRxDone), .rxData(aRxData),
    .rxParityErr(aRxErr), .rxTimeout(aRxTo),
    .lineOe(aOe), .lineOut(aOut), .lineIn(line)
  );

  swire_parity_framer #(.BIT_CYC(BC), .MAX_BITS(MB)) u_swire_parity_framer_rx (
    .clk(clk), .rstN(rstN),
    .txStart(1'b0), .txData(MB'(0)), .txLen(LW'(0)),
    .txBusy(bTxBusy), .txDone(bTxDone),
    .rxArm(bArm), .rxLen(bLen),
    .rxBusy(bBusy), .rxDone(bDone), .rxData(bData),
    .rxParityErr(bErr), .rxTimeout(bTo),
    .lineOe(bOe), .lineOut(bOut), .lineIn(line)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  task automatic check(input bit ok, input string tag, input int actual, input int expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finishRun();
    end
  end

  function automatic bit evenPar(input logic [MB-1:0] d, input int len);
    bit p = 1'b0;
    for (int k = 0; k < len; k++) p ^= d[k];
    return p;
  endfunction

  function automatic logic [MB-1:0] lowBits(input logic [MB-1:0] d, input int len);
    logic [MB-1:0] m = '0;
    for (int k = 0; k < len; k++) m[k] = 1'b1;
    return d & m;
  endfunction

  // R11 lengths per transfer; noiseBit<0 means a clean line, len means the parity bit
  task automatic runChunk(input logic [MB-1:0] d, input int len, input int noiseBit,
                          input bit doWave, input bit midStart);
    int c, busyCnt, doneCnt, rxAt, total, m, bitPos;
    logic [MB-1:0] gotData, expData;
    bit gotErr, expErr, par, expLine;
    par     = evenPar(d, len);
    expData = lowBits(d, len);
    expErr  = 1'b0;
    if (noiseBit >= 0 && noiseBit < len) begin
      bitPos           = len - 1 - noiseBit;
      expErr           = d[bitPos];
      expData[bitPos]  = 1'b0;
    end else if (noiseBit == len) begin
      expErr = par;
    end
    total = (len + 2) * BC + 12;
    @(negedge clk);
    aData = d; aLen = LW'(len); aStart = 1'b1;
    bLen = LW'(len); bArm = 1'b1;
    @(posedge clk);
    @(negedge clk);
    aStart = 1'b0; bArm = 1'b0;
    c = 0; busyCnt = 0; doneCnt = 0; rxAt = -1; gotData = '0; gotErr = 1'b0;
    while (c < total) begin
      if (aBusy) busyCnt++;
      if (aDone) doneCnt++;
      if (bDone && rxAt < 0) begin
        rxAt = c; gotData = bData; gotErr = bErr;
      end
      if (doWave) begin
        if (c < BC) expLine = 1'b0;
        else if (c == BC) expLine = 1'b1;
        else begin
          m = (c - BC - 1) / BC;
          if (m < len) expLine = d[len-1-m];
          else if (m == len) expLine = par;
          else expLine = 1'b0;
        end
        // R2 R3 R4 R5 line waveform per cycle
        check(line == expLine, "R2/R3/R4 line level", int'(line), int'(expLine));
      end
      if (midStart && c == BC + 3) begin
        aStart = 1'b1; aData = ~d; aLen = LW'(1);
        bArm = 1'b1; bLen = LW'(1);
      end
      if (midStart && c == BC + 4) begin
        aStart = 1'b0; bArm = 1'b0;
      end
      noise = (noiseBit >= 0) && (c >= BC + 1 + noiseBit * BC) && (c < BC + 1 + (noiseBit + 1) * BC);
      @(posedge clk);
      @(negedge clk);
      c++;
    end
    noise = 1'b0;
    check(rxAt == (len + 1) * BC + HALF + 2, "R6 rxDone timing", rxAt, (len + 1) * BC + HALF + 2);
    check(gotData == expData, "R7/R3 rxData", int'(gotData), int'(expData));
    check(gotErr == expErr, "R8/R4 rxParityErr", int'(gotErr), int'(expErr));
    check(busyCnt == (len + 2) * BC + 1, "R5 busy length", busyCnt, (len + 2) * BC + 1);
    check(doneCnt == 1, "R5 done count", doneCnt, 1);
    check(aOe && !aOut && !line, "R5 hold low", int'({aOe, aOut}), 2);
    if (midStart) check(!aBusy && !bBusy, "R10 restart ignored", int'({aBusy, bBusy}), 0);
  endtask

  task automatic runTimeout(input string tag);
    int n;
    bit sawDone;
    @(negedge clk);
    bLen = LW'(MB); bArm = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bArm = 1'b0;
    n = 0; sawDone = 1'b0;
    while (!bTo && n < WIN + 20) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      if (bDone) sawDone = 1'b1;
    end
    check(n == WIN, tag, n, WIN);
    check(!sawDone && !bBusy, "R9 idle after timeout", int'({sawDone, bBusy}), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(!aOe && !bOe && line, "R1 line released", int'({aOe, bOe, line}), 1);
    check(!aBusy && !aDone && !bBusy && !bDone && !bTo, "R1 flags low",
          int'({aBusy, aDone, bBusy, bDone, bTo}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!aOe && line, "R1 released after reset", int'({aOe, line}), 1);

    // R9 timeout with the line sitting high
    runTimeout("R9 timeout released line");

    // waveform checks on a few chunks
    runChunk(8'hA5, 8, -1, 1'b1, 1'b0);
    runChunk(8'h05, 3, -1, 1'b1, 1'b0);

    // R11 exhaustive sweep of every value at every length
    for (int len = 1; len <= MB; len++) begin
      for (int v = 0; v < (1 << len); v++) begin
        runChunk(MB'(v), len, -1, 1'b0, 1'b0);
      end
    end

    // R9 timeout with the line held low by the sender
    runTimeout("R9 timeout held low");

    // R10 restart requests during a chunk
    runChunk(8'h3C, 8, -1, 1'b0, 1'b1);
    runChunk(8'h01, 2, -1, 1'b0, 1'b1);

    // R8 corrupted bit windows, parity bit included
    for (int v = 0; v < 256; v += 37) begin
      for (int nb = 0; nb <= MB; nb++) begin
        runChunk(MB'(v), MB, nb, 1'b0, 1'b0);
      end
    end
    runChunk(8'h06, 3, 3, 1'b0, 1'b0);

    finishRun();
  end

endmodule